// File: doc/BRIEF.md
# Buffered Serial Transceiver with Fractional Bit-Rate Divider

This block is an asynchronous serial transmitter and receiver behind a small register port. Bytes written to the data register enter a transmit queue and leave on `txd` as start/data/parity/stop frames. Frames on `rxd` are sampled at sixteen ticks per bit, and each one is stored with four status flags in a 12-bit receive queue. Reading the data register pops the oldest receive entry. Each queue holds 16 entries by default. When queuing is switched off, each queue collapses to a single holding slot.

The tick rate comes from a divisor with a 16-bit whole part and a 6-bit fraction counted in 1/64 steps. A divisor whole part of zero stops the ticks. Each direction raises a level-sensitive interrupt against a selectable fill threshold. The receiver rejects start pulses that are too short. It reports a line held low for a whole frame as one break entry. The transmitter can hold the line low on command.

Register map (`regAddr`):
- 0: data. A write queues a byte. A read returns the receive entry and pops it.
- 1: line setup. Bits [1:0] set the word length to 5 + value. Bit 2 enables parity. Bit 3 selects odd parity. Bit 4 selects stick parity. Bit 5 selects two stop bits. Bit 6 enables queuing. Bit 7 forces a break.
- 2: divisor whole part.
- 3: divisor fraction, bits [5:0].
- 4: thresholds. Bits [2:0] select the transmit level and bits [5:3] the receive level.
- 5: status. Bit 0 is transmit full, bit 1 transmit empty, bit 2 receive full, bit 3 receive empty, bit 4 transmitter busy.

Top module: `fuart_top`

## Requirements
- R1: After reset: `txd` is 1, `rxIrq` is 0, `txIrq` is 1, and status reads 0x000A (both queues empty).
- R2: A transmitted frame has these bits in order: a 0 start bit, the data bits LSB first, an optional parity bit, then one or two stop bits at 1. Every bit lasts 16 ticks. With the fraction at zero, a tick is every (whole part) clocks. Back-to-back frames follow one another with no idle gap.
- R3: The parity bit is the XOR of the data bits for even parity and its inverse for odd parity. With stick parity (bit 4) set, the parity bit is the constant value of bit 3.
- R4: A received frame is stored with its data in bits [7:0], zero-extended above the word length, and flag bits [11:8] at zero when the frame is clean.
- R5: A parity mismatch sets entry bit 9. A stop bit sampled at 0 sets entry bit 8, unless the frame is a break.
- R6: A low pulse on `rxd` that has gone high again by the middle of the start bit is ignored and stores nothing.
- R7: If `rxd` is still low at the middle of the stop bit, and every data bit and any parity bit sampled 0, exactly one entry 0x400 is stored (data 0, break bit 10 set). Nothing more is stored until the line returns high.
- R8: While line-setup bit 7 is set, `txd` is 0. Once the bit is cleared, `txd` returns to 1.
- R9: A tick period is the whole part plus one extra clock each time the accumulated fraction overflows 64. An 8N1 frame therefore lasts exactly 160 × (whole + fraction/64) clocks when that product is an integer.
- R10: A frame that completes while the receive queue is full is discarded. The next stored entry has bit 11 (overrun) set.
- R11: Each queue holds DEPTH (16) entries. The full and empty status bits track the fill. A data write while transmit-full is dropped.
- R12: With queuing off (bit 6 = 0), each queue holds one entry. `rxIrq` then means "receive entry present" and `txIrq` means "transmit slot empty".
- R13: Level selects 0 to 4 give thresholds of 1/8, 1/4, 1/2, 3/4 and 7/8 of DEPTH (2, 4, 8, 12, 14). `rxIrq` is 1 when the receive fill is at least the threshold. `txIrq` is 1 when the transmit fill is at most its threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops receive queue at address 0) |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data, combinational from address |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| txIrq | output | 1 | Transmit threshold interrupt |
| rxIrq | output | 1 | Receive threshold interrupt |

## Verification
A stale bit counter or a wrong parity selector corrupts the very next frame on `txd` within one bit time. It is caught by sampling every bit at mid-bit across all word lengths, parity modes and stop counts. A bad queue pointer or fill count shows up in the first entry read back after a fill to capacity, or in a wrong interrupt level within the same cycle as the register write. A wrong receive state (a missed false-start reject, a repeated break entry, a lost overrun flag) appears as an unexpected empty status or entry value one frame later.

// File: rtl/fuart_pkg.sv
package fuart_pkg;

  localparam int BYTE_W  = 8;
  localparam int ENTRY_W = 12;

  localparam logic [2:0] ADDR_DATA  = 3'd0;
  localparam logic [2:0] ADDR_LINE  = 3'd1;
  localparam logic [2:0] ADDR_DIVI  = 3'd2;
  localparam logic [2:0] ADDR_DIVF  = 3'd3;
  localparam logic [2:0] ADDR_LEVEL = 3'd4;
  localparam logic [2:0] ADDR_STAT  = 3'd5;

  typedef struct packed {
    logic       sendBrk;
    logic       fifoEn;
    logic       twoStop;
    logic       parStick;
    logic       parOdd;
    logic       parEn;
    logic [1:0] wordSel;
  } lineCfg_t;

  typedef struct packed {
    logic               txPop;
    logic               rxPush;
    logic [ENTRY_W-1:0] rxEntry;
  } strobe_t;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} txState_t;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI} rxState_t;

  function automatic logic parityOf(logic [BYTE_W-1:0] d, lineCfg_t c);
    if (c.parStick) return c.parOdd;
    return (^d) ^ c.parOdd;
  endfunction

endpackage

// File: rtl/fuart_fifo.sv
module fuart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oneDeep,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = oneDeep ? !empty : (count == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdata  = mem[rdPtr];

  always_ff @(posedge clk)
    if (doPush) mem[wrPtr] <= wdata;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
endmodule

// File: rtl/fuart_ctrl.sv
module fuart_ctrl
  import fuart_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  lineCfg_t    cfg,
  input  logic [15:0] baudInt,
  input  logic [5:0]  baudFrac,
  input  logic        txEmpty,
  input  logic [7:0]  txData,
  input  logic        rxd,
  output logic        txd,
  output logic        txBusy,
  output strobe_t     strb
);
  // tick generator: whole part plus fractional carry
  logic [16:0] divCnt, divLimit;
  logic [5:0]  fracAcc;
  logic        extraCyc, tick, baudOn;

  assign baudOn   = (baudInt != 16'd0);
  assign divLimit = {1'b0, baudInt} - 17'd1 + {16'd0, extraCyc};
  assign tick     = baudOn && (divCnt >= divLimit);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      divCnt <= '0; fracAcc <= '0; extraCyc <= 1'b0;
    end else if (!baudOn) begin
      divCnt <= '0; fracAcc <= '0; extraCyc <= 1'b0;
    end else if (tick) begin
      divCnt <= '0;
      {extraCyc, fracAcc} <= {1'b0, fracAcc} + {1'b0, baudFrac};
    end else begin
      divCnt <= divCnt + 17'd1;
    end

  logic [3:0] nBits;
  logic [7:0] bitMask;
  assign nBits   = 4'd5 + {2'b00, cfg.wordSel};
  assign bitMask = 8'hFF >> (4'd8 - nBits);

  // transmitter
  txState_t txSt;
  logic [3:0] txTk;
  logic [2:0] txIdx;
  logic [7:0] txSh;
  logic txPar, txStop2, bitEnd, lastStop, txPopC, lineBit;

  assign bitEnd   = tick && (txTk == 4'd15);
  assign lastStop = (txSt == TX_STOP) && bitEnd && (!cfg.twoStop || txStop2);
  assign txPopC   = !txEmpty && (((txSt == TX_IDLE) && tick) || lastStop);
  assign txBusy   = (txSt != TX_IDLE);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      txSt <= TX_IDLE; txTk <= '0; txIdx <= '0; txSh <= '0;
      txPar <= 1'b0; txStop2 <= 1'b0;
    end else if (txPopC) begin
      txSt    <= TX_START;
      txTk    <= '0;
      txSh    <= txData & bitMask;
      txPar   <= parityOf(txData & bitMask, cfg);
      txStop2 <= 1'b0;
    end else if (lastStop) begin
      txSt <= TX_IDLE;
    end else if (tick && (txSt != TX_IDLE)) begin
      txTk <= txTk + 4'd1;
      if (bitEnd) begin
        case (txSt)
          TX_START: begin txSt <= TX_DATA; txIdx <= '0; end
          TX_DATA:
            if ({1'b0, txIdx} == nBits - 4'd1) txSt <= cfg.parEn ? TX_PAR : TX_STOP;
            else begin
              txIdx <= txIdx + 3'd1;
              txSh  <= txSh >> 1;
            end
          TX_PAR:  txSt <= TX_STOP;
          TX_STOP: txStop2 <= 1'b1;
          default: txSt <= TX_IDLE;
        endcase
      end
    end

  always_comb
    case (txSt)
      TX_START: lineBit = 1'b0;
      TX_DATA:  lineBit = txSh[0];
      TX_PAR:   lineBit = txPar;
      default:  lineBit = 1'b1;
    endcase

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) txd <= 1'b1;
    else       txd <= cfg.sendBrk ? 1'b0 : lineBit;

  // receiver
  logic rxS1, rxS2;
  rxState_t rxSt;
  logic [3:0] rxTk;
  logic [2:0] rxIdx;
  logic [7:0] rxSh;
  logic rxParBit, pushR, isBrk, parErr;
  logic [ENTRY_W-1:0] entryR;

  assign isBrk  = !rxS2 && (rxSh == 8'd0) && !(cfg.parEn && rxParBit);
  assign parErr = cfg.parEn && (rxParBit != parityOf(rxSh, cfg));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rxS1 <= 1'b1; rxS2 <= 1'b1;
    end else begin
      rxS1 <= rxd; rxS2 <= rxS1;
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rxSt <= RX_IDLE; rxTk <= '0; rxIdx <= '0; rxSh <= '0;
      rxParBit <= 1'b0; pushR <= 1'b0; entryR <= '0;
    end else begin
      pushR <= 1'b0;
      case (rxSt)
        RX_IDLE:
          if (tick && !rxS2) begin rxSt <= RX_START; rxTk <= '0; end
        RX_START:
          if (tick) begin
            if (rxTk == 4'd7) begin
              rxTk <= '0;
              if (rxS2) rxSt <= RX_IDLE;
              else begin rxSt <= RX_DATA; rxIdx <= '0; rxSh <= '0; end
            end else rxTk <= rxTk + 4'd1;
          end
        RX_DATA:
          if (tick) begin
            rxTk <= rxTk + 4'd1;
            if (rxTk == 4'd15) begin
              rxSh[rxIdx] <= rxS2;
              if ({1'b0, rxIdx} == nBits - 4'd1) rxSt <= cfg.parEn ? RX_PAR : RX_STOP;
              else rxIdx <= rxIdx + 3'd1;
            end
          end
        RX_PAR:
          if (tick) begin
            rxTk <= rxTk + 4'd1;
            if (rxTk == 4'd15) begin rxParBit <= rxS2; rxSt <= RX_STOP; end
          end
        RX_STOP:
          if (tick) begin
            rxTk <= rxTk + 4'd1;
            if (rxTk == 4'd15) begin
              pushR  <= 1'b1;
              entryR <= isBrk ? 12'h400 : {2'b00, parErr, !rxS2, rxSh};
              rxSt   <= rxS2 ? RX_IDLE : RX_WAITHI;
            end
          end
        RX_WAITHI:
          if (rxS2) rxSt <= RX_IDLE;
        default: rxSt <= RX_IDLE;
      endcase
    end

  always_comb begin
    strb.txPop   = txPopC;
    strb.rxPush  = pushR;
    strb.rxEntry = entryR;
  end
endmodule

// File: rtl/fuart_dp.sv
module fuart_dp
  import fuart_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [2:0]    regAddr,
  input  logic [15:0]   regWdata,
  output logic [15:0]   regRdata,
  input  strobe_t       strb,
  input  logic          txBusy,
  output lineCfg_t      cfg,
  output logic [15:0]   baudInt,
  output logic [5:0]    baudFrac,
  output logic          txEmpty,
  output logic [7:0]    txData,
  output logic [CW-1:0] rxCount,
  output logic          rxFull,
  output logic          rxEmpty,
  output logic          rxPop,
  output logic          txIrq,
  output logic          rxIrq
);
  logic [2:0] txLvl, rxLvl;
  logic pendOvr, txFull, txPush, rxPushOk;
  logic [CW-1:0] txCount;
  logic [ENTRY_W-1:0] rxHead;

  function automatic logic [CW-1:0] levelOf(logic [2:0] sel);
    case (sel)
      3'd0:    return CW'(DEPTH / 8);
      3'd1:    return CW'(DEPTH / 4);
      3'd2:    return CW'(DEPTH / 2);
      3'd3:    return CW'(DEPTH * 3 / 4);
      default: return CW'(DEPTH * 7 / 8);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      cfg      <= lineCfg_t'(8'h43);
      baudInt  <= '0;
      baudFrac <= '0;
      txLvl    <= 3'd2;
      rxLvl    <= 3'd2;
    end else if (regWr) begin
      case (regAddr)
        ADDR_LINE:  cfg <= lineCfg_t'(regWdata[7:0]);
        ADDR_DIVI:  baudInt <= regWdata;
        ADDR_DIVF:  baudFrac <= regWdata[5:0];
        ADDR_LEVEL: begin txLvl <= regWdata[2:0]; rxLvl <= regWdata[5:3]; end
        default: ;
      endcase
    end

  assign txPush   = regWr && (regAddr == ADDR_DATA);
  assign rxPop    = regRd && (regAddr == ADDR_DATA);
  assign rxPushOk = strb.rxPush && !rxFull;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) pendOvr <= 1'b0;
    else if (strb.rxPush) pendOvr <= rxFull;

  fuart_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) uTxq (
    .clk(clk), .rstN(rstN), .oneDeep(!cfg.fifoEn),
    .push(txPush), .pop(strb.txPop), .wdata(regWdata[7:0]),
    .rdata(txData), .count(txCount), .full(txFull), .empty(txEmpty));

  fuart_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) uRxq (
    .clk(clk), .rstN(rstN), .oneDeep(!cfg.fifoEn),
    .push(rxPushOk), .pop(rxPop), .wdata(strb.rxEntry | {pendOvr, 11'd0}),
    .rdata(rxHead), .count(rxCount), .full(rxFull), .empty(rxEmpty));

  assign rxIrq = cfg.fifoEn ? (!rxEmpty && (rxCount >= levelOf(rxLvl))) : !rxEmpty;
  assign txIrq = cfg.fifoEn ? (txCount <= levelOf(txLvl)) : txEmpty;

  always_comb
    case (regAddr)
      ADDR_DATA:  regRdata = {4'd0, rxHead};
      ADDR_LINE:  regRdata = {8'd0, cfg};
      ADDR_DIVI:  regRdata = baudInt;
      ADDR_DIVF:  regRdata = {10'd0, baudFrac};
      ADDR_LEVEL: regRdata = {10'd0, rxLvl, txLvl};
      ADDR_STAT:  regRdata = {11'd0, txBusy, rxEmpty, rxFull, txEmpty, txFull};
      default:    regRdata = 16'd0;
    endcase
endmodule

// File: rtl/fuart_top.sv
module fuart_top
  import fuart_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [2:0]  regAddr,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  input  logic        rxd,
  output logic        txd,
  output logic        txIrq,
  output logic        rxIrq
);
  lineCfg_t cfg;
  strobe_t strb;
  logic [15:0] baudInt;
  logic [5:0] baudFrac;
  logic txEmpty, txBusy, rxFull, rxEmpty, rxPop;
  logic [7:0] txData;
  logic [CW-1:0] rxCount;

  fuart_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .baudInt(baudInt), .baudFrac(baudFrac),
    .txEmpty(txEmpty), .txData(txData), .rxd(rxd), .txd(txd), .txBusy(txBusy),
    .strb(strb));

  fuart_dp #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strb(strb), .txBusy(txBusy),
    .cfg(cfg), .baudInt(baudInt), .baudFrac(baudFrac), .txEmpty(txEmpty),
    .txData(txData), .rxCount(rxCount), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .rxPop(rxPop), .txIrq(txIrq), .rxIrq(rxIrq));
endmodule

// File: rtl/fuart_chk.sv
module fuart_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          txd,
  input logic          sendBrk,
  input logic          txBusy,
  input logic [CW-1:0] rxCount,
  input logic          rxFull,
  input logic          rxEmpty,
  input logic          rxPush,
  input logic          rxPop,
  input logic          rxIrq
);
  AST_BRK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    sendBrk |=> !txd); // R8
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rstN)
    $past(!txBusy && !sendBrk) |-> txd); // R2
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CW'(DEPTH)); // R11
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rxFull && rxEmpty)); // R11
  AST_OVR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && rxPush && !rxPop) |=> $stable(rxCount)); // R10
  AST_RXIRQ_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> !rxEmpty); // R13
endmodule

bind fuart_top fuart_chk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .txd(txd), .sendBrk(cfg.sendBrk), .txBusy(txBusy),
  .rxCount(rxCount), .rxFull(rxFull), .rxEmpty(rxEmpty), .rxPush(strb.rxPush),
  .rxPop(rxPop), .rxIrq(rxIrq));

// File: tb/sim_fuart_top.sv
module sim_fuart_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic lineIn = 1'b1;
  logic txd, txIrq, rxIrq;
  int errs = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fuart_top u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .rxd(lineIn), .txd(txd),
    .txIrq(txIrq), .rxIrq(rxIrq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); regRd = 1'b1; regAddr = a; #1 d = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  function automatic logic [7:0] cfgWord(int wl, int mode, int st, bit fifo);
    logic pe, odd, stick;
    pe = (mode != 0); odd = (mode == 2 || mode == 4); stick = (mode >= 3);
    return {1'b0, fifo, st[0], stick, odd, pe, 2'(wl - 5)};
  endfunction

  function automatic logic expPar(logic [7:0] d, int mode);
    case (mode)
      1: return ^d;
      2: return ~^d;
      3: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic sendFrame(input logic [7:0] d, input int nb, input bit pe, input bit pb,
                           input bit stopV, input int ns);
    lineIn = 1'b0; repeat (32) @(negedge clk);
    for (int i = 0; i < nb; i++) begin lineIn = d[i]; repeat (32) @(negedge clk); end
    if (pe) begin lineIn = pb; repeat (32) @(negedge clk); end
    lineIn = stopV; repeat (32) @(negedge clk);
    for (int i = 1; i < ns; i++) begin lineIn = 1'b1; repeat (32) @(negedge clk); end
    lineIn = 1'b1; repeat (48) @(negedge clk);
  endtask

  task automatic capture(input int nb, input bit pe, input int ns,
                         output logic [7:0] d, output logic p, output bit stopsOk);
    int guard = 0;
    while (txd !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
    repeat (16) @(negedge clk);
    d = 8'd0;
    for (int i = 0; i < nb; i++) begin repeat (32) @(negedge clk); d[i] = txd; end
    p = 1'b0;
    if (pe) begin repeat (32) @(negedge clk); p = txd; end
    stopsOk = 1;
    for (int i = 0; i < ns; i++) begin repeat (32) @(negedge clk); if (txd !== 1'b1) stopsOk = 0; end
  endtask

  task automatic framePeriod(output int cyc);
    cyc = 0;
    while (txd !== 1'b0) @(negedge clk);
    while (txd !== 1'b1) @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    while (txd !== 1'b1) begin @(negedge clk); cyc++; end
    while (txd !== 1'b0) begin @(negedge clk); cyc++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0] d, b, m;
    logic p;
    bit sok;
    int cyc;
    int thr [5] = '{2, 4, 8, 12, 14};

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1, "R1 txd", txd, 1);
    chk(rxIrq === 1'b0, "R1 rxIrq", rxIrq, 0);
    chk(txIrq === 1'b1, "R1 txIrq", txIrq, 1);
    rd(3'd5, v); chk(v === 16'h000A, "R1 status", v, 16'h000A);

    wr(3'd2, 16'd2);
    // R2 R3 R4 sweep over word length, parity mode, stop count
    for (int wl = 5; wl <= 8; wl++)
      for (int mode = 0; mode < 5; mode++)
        for (int st = 0; st < 2; st++) begin
          wr(3'd1, {8'd0, cfgWord(wl, mode, st, 1'b1)});
          b = 8'hA5 ^ 8'(wl * 37 + mode * 11 + st * 3);
          m = 8'hFF >> (8 - wl);
          wr(3'd0, {8'd0, b});
          capture(wl, mode != 0, st + 1, d, p, sok);
          chk(d === (b & m), "R2 tx data", d, b & m);
          chk(sok, "R2 tx stop bits", sok, 1);
          if (mode != 0) chk(p === expPar(b & m, mode), "R3 tx parity", p, expPar(b & m, mode));
          repeat (40) @(negedge clk);
          sendFrame(b, wl, mode != 0, expPar(b & m, mode), 1'b1, st + 1);
          rd(3'd0, v);
          chk(v === {8'd0, b & m}, "R4 rx entry", v, {8'd0, b & m});
        end

    // R2 R9 frame period, integer and fractional divisors
    wr(3'd1, 16'h0043);
    for (int k = 0; k < 3; k++) wr(3'd0, 16'h00FF);
    framePeriod(cyc); chk(cyc == 320, "R2 period div 2", cyc, 320);
    repeat (1200) @(negedge clk);
    wr(3'd3, 16'd32);
    for (int k = 0; k < 3; k++) wr(3'd0, 16'h00FF);
    framePeriod(cyc); chk(cyc >= 399 && cyc <= 401, "R9 period div 2+32/64", cyc, 400);
    repeat (1500) @(negedge clk);
    wr(3'd2, 16'd3); wr(3'd3, 16'd16);
    for (int k = 0; k < 3; k++) wr(3'd0, 16'h00FF);
    framePeriod(cyc); chk(cyc >= 519 && cyc <= 521, "R9 period div 3+16/64", cyc, 520);
    repeat (2000) @(negedge clk);
    wr(3'd2, 16'd2); wr(3'd3, 16'd0);

    // R5 parity and framing errors (8E1)
    wr(3'd1, 16'h0047);
    sendFrame(8'h5A, 8, 1, 1'b1, 1'b1, 1);
    rd(3'd0, v); chk(v === 16'h025A, "R5 parity error", v, 16'h025A);
    sendFrame(8'h33, 8, 1, 1'b0, 1'b0, 1);
    rd(3'd0, v); chk(v === 16'h0133, "R5 framing error", v, 16'h0133);

    // R6 false start
    wr(3'd1, 16'h0043);
    lineIn = 1'b0; repeat (8) @(negedge clk); lineIn = 1'b1;
    repeat (400) @(negedge clk);
    rd(3'd5, v); chk(v[3] === 1'b1, "R6 glitch stores nothing", v[3], 1);
    sendFrame(8'h96, 8, 0, 1'b0, 1'b1, 1);
    rd(3'd0, v); chk(v === 16'h0096, "R6 frame after glitch", v, 16'h0096);

    // R7 break detection
    lineIn = 1'b0; repeat (800) @(negedge clk); lineIn = 1'b1;
    repeat (100) @(negedge clk);
    rd(3'd0, v); chk(v === 16'h0400, "R7 break entry", v, 16'h0400);
    rd(3'd5, v); chk(v[3] === 1'b1, "R7 single entry", v[3], 1);

    // R8 break generation
    wr(3'd1, 16'h00C3); repeat (3) @(negedge clk);
    chk(txd === 1'b0, "R8 break low", txd, 0);
    wr(3'd1, 16'h0043); repeat (3) @(negedge clk);
    chk(txd === 1'b1, "R8 break released", txd, 1);

    // R13 R11 receive thresholds and depth
    for (int k = 1; k <= 16; k++) begin
      sendFrame(8'(k), 8, 0, 1'b0, 1'b1, 1);
      for (int s = 0; s < 5; s++) begin
        wr(3'd4, 16'((s << 3) | 2));
        chk(rxIrq === (k >= thr[s]), "R13 rx threshold", rxIrq, k >= thr[s]);
      end
    end
    rd(3'd5, v); chk(v[2] === 1'b1, "R11 rx full", v[2], 1);
    sendFrame(8'hEE, 8, 0, 1'b0, 1'b1, 1);
    for (int k = 1; k <= 16; k++) begin
      rd(3'd0, v); chk(v === 16'(k), "R10 R11 rx order, dropped frame absent", v, k);
    end
    rd(3'd5, v); chk(v[3] === 1'b1, "R11 rx empty", v[3], 1);
    sendFrame(8'h77, 8, 0, 1'b0, 1'b1, 1);
    rd(3'd0, v); chk(v === 16'h0877, "R10 overrun flag", v, 16'h0877);

    // R13 R11 transmit thresholds and drop while full
    wr(3'd2, 16'd0);
    for (int n = 1; n <= 16; n++) begin
      wr(3'd0, 16'(n));
      for (int s = 0; s < 5; s++) begin
        wr(3'd4, 16'((2 << 3) | s));
        chk(txIrq === (n <= thr[s]), "R13 tx threshold", txIrq, n <= thr[s]);
      end
    end
    rd(3'd5, v); chk(v[0] === 1'b1, "R11 tx full", v[0], 1);
    wr(3'd0, 16'h00AB);
    wr(3'd2, 16'd2);
    for (int n = 1; n <= 16; n++) begin
      capture(8, 0, 1, d, p, sok);
      chk(d === 8'(n), "R11 tx order", d, n);
    end
    repeat (600) @(negedge clk);
    rd(3'd5, v); chk(v[1:0] === 2'b10 && v[4] === 1'b0, "R11 tx write while full dropped", v, 16'h000A);

    // R12 one-deep mode
    wr(3'd1, 16'h0003);
    sendFrame(8'h11, 8, 0, 1'b0, 1'b1, 1);
    rd(3'd5, v); chk(v[2] === 1'b1, "R12 rx full at one", v[2], 1);
    chk(rxIrq === 1'b1, "R12 rxIrq present", rxIrq, 1);
    sendFrame(8'h22, 8, 0, 1'b0, 1'b1, 1);
    rd(3'd0, v); chk(v === 16'h0011, "R12 rx holds first", v, 16'h0011);
    sendFrame(8'h33, 8, 0, 1'b0, 1'b1, 1);
    rd(3'd0, v); chk(v === 16'h0833, "R12 overrun one-deep", v, 16'h0833);
    wr(3'd2, 16'd0);
    wr(3'd0, 16'h0044);
    rd(3'd5, v); chk(v[0] === 1'b1, "R12 tx full at one", v[0], 1);
    chk(txIrq === 1'b0, "R12 txIrq slot taken", txIrq, 0);
    wr(3'd0, 16'h0055);
    wr(3'd2, 16'd2);
    capture(8, 0, 1, d, p, sok);
    chk(d === 8'h44, "R12 tx holds first", d, 8'h44);
    repeat (600) @(negedge clk);
    rd(3'd5, v); chk(v[1] === 1'b1 && v[4] === 1'b0, "R12 second write dropped", v, 16'h000A);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule